// File: doc/BRIEF.md
# Signed/Unsigned Integer Multiplier with Flags

This block multiplies two 32-bit integers and returns a 64-bit product plus zero and negative condition flags. A mode input picks how the operands are sized and interpreted. Byte, word and longword multiplies sign-extend their operands and return a result truncated to the operand size. The extended signed multiply and the unsigned full-magnitude multiply return all 64 bits. There is no Booth recoding. Signed arithmetic uses a Baugh-Wooley partial-product array, and the same array also serves unsigned operands by widening every operand by one bit.

A partial-product mode helps build a wider multiply out of several instances. Each instance multiplies two unsigned 16-bit halves of its operands. On the first beat it multiplies the two high halves. On the second beat a configuration field picks one cross product, so different instances can produce different terms of the wide result. Operands are not registered at the input. The product is captured one clock after a valid request, and the flags are derived from that captured value. The wide accumulation of partial terms happens outside the block.

Top module: `int_mul_flags`

## Requirements
- R1: Mode code 0 (byte): bits [7:0] of each operand are treated as signed. The product output holds the low 8 bits of their product, sign-extended from bit 7 to 64 bits.
- R2: Mode code 1 (word): bits [15:0] of each operand are treated as signed. The product output holds the low 16 bits of their product, sign-extended from bit 15.
- R3: Mode code 2 (longword): the full 32-bit operands are treated as signed. The product output holds the low 32 bits of their product, sign-extended from bit 31.
- R4: Mode code 3 (extended signed), and the unused codes 6 and 7: the full 64-bit two's-complement product of the signed 32-bit operands.
- R5: Mode code 4 (unsigned magnitude): the full 64-bit product of both operands read as unsigned.
- R6: Mode code 5 (partial): the high half is bits [31:16] and the low half is bits [15:0]. Both halves are unsigned. With `beat` low, the product is A-high times B-high. With `beat` high, `cross_sel` 0 gives A-high times B-low, 1 gives A-low times B-high, and 2 or 3 gives A-low times B-low. The 32-bit product is zero-extended.
- R7: `flag_z` is 1 exactly when the result at the mode's width is zero. `flag_n` is the top bit of the result at that width: bit 7, 15, 31 or 63 for the sized modes, and bit 31 in partial mode.
- R8: The product, flags and `out_valid` reflect a request presented with `in_valid` high on the next clock edge. `out_valid` is low after any edge where `in_valid` was low.
- R9: While `in_valid` is low, the product and both flags keep their values, whatever the operands and mode do.
- R10: After reset, `out_valid` is 0, the product is 0, `flag_z` is 1 and `flag_n` is 0.
- R11: Results that overflow the result width wrap. This includes the most-negative operand cases: in byte mode -128 times -128 gives 0 with `flag_z` set, and in extended mode -2^31 times -2^31 gives 2^62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; the operands are sampled on this edge |
| op_mode | input | 3 | Multiply mode code (see R1 to R6) |
| beat | input | 1 | Partial mode: 0 selects the first beat, 1 the second |
| cross_sel | input | 2 | Partial mode: cross product taken on the second beat |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| out_valid | output | 1 | The captured product belongs to a request from the previous edge |
| product | output | 64 | Shaped product |
| flag_z | output | 1 | Zero flag of the result |
| flag_n | output | 1 | Negative flag of the result |

## Verification
Byte mode is swept over all 65,536 operand pairs. This covers every combination of sign bits and the -128 corner, so it separates correct Baugh-Wooley sign handling from the most likely error, a missing correction term. Word, longword, extended and unsigned modes are tried with a cross product of boundary values (0, 1, -1, the most-negative and most-positive values) and with random operands. This separates truncation and sign-extension mistakes from zero-extension mistakes. Partial mode is run with random operands for both beats and all four `cross_sel` codes, which shows whether the two halves are swapped. Idle cycles with changing inputs confirm that the captured product and flags hold.

// File: rtl/int_mul_pkg.sv
// Shared mode encoding for the integer multiplier.
// The numeric codes are decoded from the op_mode port.
package int_mul_pkg;

    typedef enum logic [2:0] {
        MM_BYTE = 3'd0,
        MM_WORD = 3'd1,
        MM_LONG = 3'd2,
        MM_EXT  = 3'd3,
        MM_UMAG = 3'd4,
        MM_PART = 3'd5
    } mul_mode_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned WORD_BITS = 16;

endpackage

// File: rtl/int_mul_sizer.sv
// Operand sizer: widens one operand to W+1 bits so that a single signed
// array can serve every mode. Sized signed modes sign-extend from their
// top bit. The unsigned and partial modes zero-extend. Partial mode picks
// the high or low half, as told by take_high.
// Assumes: W is even and at least 16.
module int_mul_sizer
    import int_mul_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opnd,
    input  mul_mode_e    mode,
    input  logic         take_high,
    output logic [W:0]   ext
);
    localparam int unsigned HALF = W / 2;

    // Select and extend the operand field for the active mode.
    always_comb begin
        unique case (mode)
            MM_BYTE: ext = {{(W + 1 - BYTE_BITS){opnd[BYTE_BITS-1]}}, opnd[BYTE_BITS-1:0]};
            MM_WORD: ext = {{(W + 1 - WORD_BITS){opnd[WORD_BITS-1]}}, opnd[WORD_BITS-1:0]};
            MM_UMAG: ext = {1'b0, opnd};
            MM_PART: ext = take_high ? {{(HALF + 1){1'b0}}, opnd[W-1:HALF]}
                                     : {{(HALF + 1){1'b0}}, opnd[HALF-1:0]};
            default: ext = {opnd[W-1], opnd};
        endcase
    end

endmodule

// File: rtl/int_mul_bw_array.sv
// Baugh-Wooley signed multiplier for N = W+1 bit operands, with no Booth
// recoding. Each partial-product bit whose weight involves exactly one
// sign bit is inverted, and a correction constant is added. The sum is
// kept modulo 2^(2W): the 2^(2N-1) correction term and the top product
// bit fall outside that width, so only 2^(W+1) remains as the constant.
// Assumes: operands are already sign- or zero-extended to W+1 bits.
module int_mul_bw_array #(
    parameter int unsigned W = 32
) (
    input  logic [W:0]     a,
    input  logic [W:0]     b,
    output logic [2*W-1:0] p
);
    localparam int unsigned N  = W + 1;
    localparam int unsigned PW = 2 * W;
    localparam logic [PW-1:0] BW_CONST = PW'(1) << (W + 1);

    logic [PW-1:0] rows [N];
    logic [PW-1:0] acc  [N+1];

    genvar j;
    generate
        for (j = 0; j < N; j++) begin : g_row
            logic [N-1:0] bits;
            // Form one partial-product row with Baugh-Wooley inversion.
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    bits[i] = (a[i] & b[j]) ^ ((i == N - 1) != (j == N - 1));
                end
            end
            assign rows[j] = {{(PW - N){1'b0}}, bits} << j;
        end
    endgenerate

    assign acc[0] = BW_CONST;

    generate
        for (j = 0; j < N; j++) begin : g_sum
            // Accumulate row j into the running sum.
            assign acc[j+1] = acc[j] + rows[j];
        end
    endgenerate

    assign p = acc[N];

endmodule

// File: rtl/int_mul_shaper.sv
// Result shaper: takes the latched raw product and the latched mode. It
// truncates the result to the mode's width, extends it to the full
// output width, and derives the zero and negative flags from that value.
// Assumes: the raw product is correct modulo 2^(2W).
module int_mul_shaper
    import int_mul_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] raw_q,
    input  mul_mode_e      mode_q,
    output logic [2*W-1:0] product,
    output logic           flag_z,
    output logic           flag_n
);
    localparam int unsigned PW = 2 * W;

    // Truncate and extend the latched product to the mode's result width.
    always_comb begin
        unique case (mode_q)
            MM_BYTE: product = {{(PW - BYTE_BITS){raw_q[BYTE_BITS-1]}}, raw_q[BYTE_BITS-1:0]};
            MM_WORD: product = {{(PW - WORD_BITS){raw_q[WORD_BITS-1]}}, raw_q[WORD_BITS-1:0]};
            MM_LONG: product = {{W{raw_q[W-1]}}, raw_q[W-1:0]};
            MM_PART: product = {{W{1'b0}}, raw_q[W-1:0]};
            default: product = raw_q;
        endcase
    end

    // Derive the flags from the shaped, latched result.
    always_comb begin
        flag_z = (product == '0);
        flag_n = (mode_q == MM_PART) ? product[W-1] : product[PW-1];
    end

endmodule

// File: rtl/int_mul_flags.sv
// Top of the integer multiplier. It decodes the mode, sizes both operands
// combinationally (the operands are not registered), runs the Baugh-Wooley
// array, and latches the raw product and mode when in_valid is high. The
// shaped product and flags come from the latched state, so they change
// only on an edge with in_valid high.
// Assumes: W is even and at least 16.
module int_mul_flags
    import int_mul_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op_mode,
    input  logic             beat,
    input  logic [1:0]       cross_sel,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic             out_valid,
    output logic [2*W-1:0]   product,
    output logic             flag_z,
    output logic             flag_n
);
    localparam int unsigned PW = 2 * W;

    mul_mode_e      mode_d;
    mul_mode_e      mode_q;
    logic           a_high;
    logic           b_high;
    logic [W:0]     a_ext;
    logic [W:0]     b_ext;
    logic [PW-1:0]  raw_d;
    logic [PW-1:0]  raw_q;
    logic           vld_q;

    // Map the mode code to a mode; unused codes act as extended signed.
    always_comb begin
        if (op_mode > 3'd5) mode_d = MM_EXT;
        else                mode_d = mul_mode_e'(op_mode);
    end

    // Pick the operand halves for the partial-product beats.
    always_comb begin
        if (!beat) begin
            a_high = 1'b1;
            b_high = 1'b1;
        end else begin
            a_high = (cross_sel == 2'd0);
            b_high = (cross_sel == 2'd1);
        end
    end

    int_mul_sizer #(.W(W)) u_size_a (
        .opnd      (opa),
        .mode      (mode_d),
        .take_high (a_high),
        .ext       (a_ext)
    );

    int_mul_sizer #(.W(W)) u_size_b (
        .opnd      (opb),
        .mode      (mode_d),
        .take_high (b_high),
        .ext       (b_ext)
    );

    int_mul_bw_array #(.W(W)) u_array (
        .a (a_ext),
        .b (b_ext),
        .p (raw_d)
    );

    // Latch the raw product and mode on a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mode_q <= MM_BYTE;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                raw_q  <= raw_d;
                mode_q <= mode_d;
            end
        end
    end

    int_mul_shaper #(.W(W)) u_shape (
        .raw_q   (raw_q),
        .mode_q  (mode_q),
        .product (product),
        .flag_z  (flag_z),
        .flag_n  (flag_n)
    );

    assign out_valid = vld_q;

endmodule

// File: rtl/int_mul_flags_chk.sv
// Checker for int_mul_flags. It watches only the ports and relates each
// request to the output one edge later.
module int_mul_flags_chk #(
    parameter int unsigned W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [2:0]     op_mode,
    input logic           out_valid,
    input logic [2*W-1:0] product,
    input logic           flag_z,
    input logic           flag_n
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_product_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(product) && $stable(flag_z) && $stable(flag_n));

    p_byte_signext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_mode == 3'd0) |=>
        (product[2*W-1:7] == '0 || product[2*W-1:7] == '1));

    p_part_zero_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_mode == 3'd5) |=> (product[2*W-1:W] == '0));

    p_ext_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_mode == 3'd3) |=> (flag_z == (product == '0)));

    p_umag_neg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_mode == 3'd4) |=> (flag_n == product[2*W-1]));

endmodule

bind int_mul_flags int_mul_flags_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_mode   (op_mode),
    .out_valid (out_valid),
    .product   (product),
    .flag_z    (flag_z),
    .flag_n    (flag_n)
);

// File: tb/int_mul_flags_bench.sv
// Self-checking bench: an exhaustive byte sweep, boundary crosses and
// random vectors for every mode. Expected values are computed arithmetically.
module int_mul_flags_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_mode = 3'd0;
    logic        beat = 1'b0;
    logic [1:0]  cross_sel = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [63:0] product;
    logic        flag_z;
    logic        flag_n;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    int_mul_flags u_int_mul_flags (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .beat(beat), .cross_sel(cross_sel), .opa(opa), .opb(opb),
        .out_valid(out_valid), .product(product), .flag_z(flag_z), .flag_n(flag_n)
    );

    function automatic logic [63:0] ref_prod(input logic [2:0] m, input logic bt,
                                             input logic [1:0] cs,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [15:0] ha, hb;
        case (m)
            3'd0: begin
                p = 64'(longint'($signed(a[7:0])) * longint'($signed(b[7:0])));
                return {{56{p[7]}}, p[7:0]};
            end
            3'd1: begin
                p = 64'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
                return {{48{p[15]}}, p[15:0]};
            end
            3'd2: begin
                p = 64'(longint'($signed(a)) * longint'($signed(b)));
                return {{32{p[31]}}, p[31:0]};
            end
            3'd4: return {32'd0, a} * {32'd0, b};
            3'd5: begin
                ha = (!bt || cs == 2'd0) ? a[31:16] : a[15:0];
                hb = (!bt || cs == 2'd1) ? b[31:16] : b[15:0];
                return {32'd0, 16'd0, ha} * {32'd0, 16'd0, hb};
            end
            default: return 64'(longint'($signed(a)) * longint'($signed(b)));
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] ep,
                         input logic ez, input logic en, input logic ev);
        nvec++;
        if (product !== ep || flag_z !== ez || flag_n !== en || out_valid !== ev) begin
            nfail++;
            $display("FAIL %s: got p=%h z=%0b n=%0b v=%0b expected p=%h z=%0b n=%0b v=%0b",
                     tag, product, flag_z, flag_n, out_valid, ep, ez, en, ev);
        end
    endtask

    // Apply one request and check it on the following falling edge.
    task automatic apply(input string tag, input logic [2:0] m, input logic bt,
                         input logic [1:0] cs, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ep;
        ep = ref_prod(m, bt, cs, a, b);
        in_valid = 1'b1; op_mode = m; beat = bt; cross_sel = cs; opa = a; opb = b;
        @(negedge clk);
        check(tag, ep, ep == 64'd0, (m == 3'd5) ? ep[31] : ep[63], 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] corners [10];
        logic [63:0] held;
        logic        hz, hn;
        corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                    32'h0000_8000, 32'h0000_7FFF, 32'h0000_0080, 32'h0000_007F, 32'hFFFF_8000};

        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10", 64'd0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 64'd0, 1'b1, 1'b0, 1'b0);

        // R1: exhaustive byte sweep; upper bits carry noise.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                apply("R1", 3'd0, 1'b0, 2'd0, {$urandom} << 8 | 32'(x), {$urandom} << 8 | 32'(y));
            end
        end

        // R11: most-negative corners.
        apply("R11", 3'd0, 1'b0, 2'd0, 32'h80, 32'h80);
        apply("R11", 3'd3, 1'b0, 2'd0, 32'h8000_0000, 32'h8000_0000);
        apply("R11", 3'd1, 1'b0, 2'd0, 32'h8000, 32'h8000);
        apply("R11", 3'd2, 1'b0, 2'd0, 32'h8000_0000, 32'h8000_0000);

        // R2 R3 R4 R5 R7: boundary cross in each sized mode.
        for (int i = 0; i < 10; i++) begin
            for (int k = 0; k < 10; k++) begin
                apply("R2", 3'd1, 1'b0, 2'd0, corners[i], corners[k]);
                apply("R3", 3'd2, 1'b0, 2'd0, corners[i], corners[k]);
                apply("R4", 3'd3, 1'b0, 2'd0, corners[i], corners[k]);
                apply("R5", 3'd4, 1'b0, 2'd0, corners[i], corners[k]);
                apply("R7", 3'd6, 1'b0, 2'd0, corners[i], corners[k]);
            end
        end

        // Random operands across all modes, including R6 beats and selects.
        for (int r = 0; r < 2000; r++) begin
            apply("R2", 3'd1, 1'b0, 2'd0, $urandom, $urandom);
            apply("R3", 3'd2, 1'b0, 2'd0, $urandom, $urandom);
            apply("R4", 3'd3, 1'b0, 2'd0, $urandom, $urandom);
            apply("R4", 3'd7, 1'b0, 2'd0, $urandom, $urandom);
            apply("R5", 3'd4, 1'b0, 2'd0, $urandom, $urandom);
            apply("R6", 3'd5, 1'b0, 2'(r), $urandom, $urandom);
            apply("R6", 3'd5, 1'b1, 2'(r), $urandom, $urandom);
        end

        // R9 and R8: idle cycles with changing inputs hold the result.
        apply("R9", 3'd2, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0003);
        held = product; hz = flag_z; hn = flag_n;
        for (int t = 0; t < 20; t++) begin
            in_valid = 1'b0; op_mode = 3'(t); beat = t[0]; cross_sel = 2'(t);
            opa = $urandom; opb = $urandom;
            @(negedge clk);
            check("R9", held, hz, hn, 1'b0);
        end
        apply("R8", 3'd4, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8", 64'hFFFF_FFFE_0000_0001, 1'b0, 1'b1, 1'b0);

        finish_run();
    end

endmodule